// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Supervisor

This block turns two push-buttons into a deliberate hard-reset request. A reset pulse is produced only when both buttons are held down together for a setup time of 2, 6 or 10 seconds, chosen by a three-level selector. Shorter presses, or a press of one button alone, have no effect. The buttons can therefore also serve as an ordinary interrupt source, and only a held double press ends in a hard reset.

The same pulse stretcher also serves the supply: while the digital supply-good input is low the reset output is held low, and it stays low for the pulse length after supply-good returns. The block's own reset input gives a power-on pulse of the same length. All timing counts a periodic tick enable (nominally 1 ms) on one system clock. The pulse length is a build option of 140 ms or 240 ms.

Top module: `dual_button_reset_sup`

## Requirements
- R1: A reset pulse is produced when both button inputs (active-low) are seen low together for the selected setup time, counted in ticks.
- R2: A double press released before the setup time ends, or a press of only one button however long, leaves rst_out_n high.
- R3: dly_sel 2'b00 selects 2000 ms, 2'b01 selects 6000 ms, 2'b10 selects 10000 ms, and 2'b11 also selects 6000 ms.
- R4: Each button passes two synchroniser flops. When both go low just after a clock edge, rst_out_n goes low right after the edge that counts the last needed tick, which is edge number N+2 for a setup time of N ticks.
- R5: Each reset pulse lasts exactly the pulse length in ticks: 240 ms with LONG_PULSE=1 and 140 ms with LONG_PULSE=0.
- R6: rst_out_n is low while supply_ok is low, and it stays low for the pulse length after supply_ok returns high.
- R7: rst_out_n is low while rst_n is low, and it stays low for the pulse length after rst_n is released.
- R8: After a button reset, no new measurement starts until at least one button has been released and no double press has been seen for 10 ms. A double press during that interval restarts the interval.
- R9: Setup timing and pulse timing advance only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset; also starts the power-on pulse |
| tick | input | 1 | Time-base enable, one pulse per millisecond (times TICKS_PER_MS) |
| btn_a_n | input | 1 | First push-button, active-low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active-low, asynchronous |
| dly_sel | input | 2 | Setup time select: 00 short, 01 middle, 10 long, 11 middle |
| supply_ok | input | 1 | Digital supply-good flag, synchronous to clk |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The assertions assume that supply_ok is already synchronous to clk and that dly_sel is steady during a press. A change of dly_sel in mid-press is tolerated by the design, but no property depends on it. The stimulus changes buttons, selector and supply only at falling clock edges. It changes dly_sel only while both buttons are released, and it keeps the gaps between presses longer than the re-arm interval, except in the test that targets that interval. The tick is held high for most of the run, so one tick equals one clock. It is held low only in the test that checks that timing freezes without ticks.

// File: rtl/dual_button_reset_sup.sv
module dual_button_reset_sup #(
  parameter int TICKS_PER_MS = 1,
  parameter bit LONG_PULSE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_a_n,
  input  logic       btn_b_n,
  input  logic [1:0] dly_sel,
  input  logic       supply_ok,
  output logic       rst_out_n
);
  localparam int SHORT_T = 2000 * TICKS_PER_MS;
  localparam int MID_T   = 6000 * TICKS_PER_MS;
  localparam int LONG_T  = 10000 * TICKS_PER_MS;
  localparam int PULSE_T = (LONG_PULSE ? 240 : 140) * TICKS_PER_MS;
  localparam int GUARD_T = 10 * TICKS_PER_MS;
  localparam int CW      = $clog2(LONG_T + 1);

  typedef enum logic [1:0] {ARMED, LOCKED, GUARD} st_t;

  logic [1:0]    a_sync, b_sync;
  logic          held, fire;
  logic [CW-1:0] target, press_cnt, guard_cnt, rec_cnt;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sync <= 2'b11;
      b_sync <= 2'b11;
    end else begin
      a_sync <= {a_sync[0], btn_a_n};
      b_sync <= {b_sync[0], btn_b_n};
    end

  assign held = ~a_sync[1] & ~b_sync[1];

  always_comb
    case (dly_sel)
      2'b00:   target = CW'(SHORT_T);
      2'b10:   target = CW'(LONG_T);
      default: target = CW'(MID_T);
    endcase

  assign fire = (st == ARMED) && held && tick && (press_cnt >= target - CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ARMED;
      press_cnt <= '0;
      guard_cnt <= '0;
    end else begin
      if (st != ARMED || !held || fire) press_cnt <= '0;
      else if (tick)                    press_cnt <= press_cnt + CW'(1);
      case (st)
        ARMED:  if (fire) st <= LOCKED;
        LOCKED: if (!held) begin
          st        <= GUARD;
          guard_cnt <= '0;
        end
        default:
          if (held) guard_cnt <= '0;
          else if (tick) begin
            if (guard_cnt == CW'(GUARD_T - 1)) begin
              st        <= ARMED;
              guard_cnt <= '0;
            end else guard_cnt <= guard_cnt + CW'(1);
          end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  rec_cnt <= CW'(PULSE_T);
    else if (!supply_ok || fire) rec_cnt <= CW'(PULSE_T);
    else if (tick && rec_cnt != '0) rec_cnt <= rec_cnt - CW'(1);

  assign rst_out_n = (rec_cnt == '0);

  // R4: a met setup time drives the output low on the next cycle
  a_r4_fire_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !rst_out_n);
  // R1 / R2: an output fall with supply good needs a held double press
  a_r2_fall_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_out_n) && $past(supply_ok)) |-> $past(held));
  // R6: supply loss forces reset
  a_r6_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rst_out_n);
  // R6: release only after a cycle with supply good
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(supply_ok));
  // R9: pulse timing is frozen without a tick
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && supply_ok && !fire) |=> $stable(rec_cnt));
  // R8: no new trigger while the press is still held after a trigger
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOCKED && held) |=> (st == LOCKED && !fire));
endmodule

// File: tb/tb_dual_button_reset_sup.sv
module tb_dual_button_reset_sup;
  localparam int PULSE = 240;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic btn_a_n = 1'b1, btn_b_n = 1'b1, supply_ok = 1'b1;
  logic [1:0] dly_sel = 2'b00;
  logic rst_out_n;
  int n_chk = 0, n_fail = 0, low_cnt = 0;

  dual_button_reset_sup dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .dly_sel(dly_sel), .supply_ok(supply_ok), .rst_out_n(rst_out_n));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (!rst_out_n) low_cnt++;

  typedef struct packed {logic [1:0] sel; logic [15:0] hold; logic fires;} vec_t;
  localparam vec_t VECS [9] = '{
    '{2'b00, 16'd3,     1'b0},
    '{2'b00, 16'd1999,  1'b0},
    '{2'b00, 16'd2000,  1'b1},
    '{2'b01, 16'd5999,  1'b0},
    '{2'b01, 16'd6000,  1'b1},
    '{2'b10, 16'd9999,  1'b0},
    '{2'b10, 16'd10000, 1'b1},
    '{2'b11, 16'd5999,  1'b0},
    '{2'b11, 16'd6000,  1'b1}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    negs(3);
    check(rst_out_n == 1'b0, "R7 held in reset", rst_out_n, 0);
    rst_n = 1'b1;
    negs(PULSE - 1);
    check(rst_out_n == 1'b0, "R7 power-on pulse end-1", rst_out_n, 0);
    negs(1);
    check(rst_out_n == 1'b1, "R7 power-on pulse end", rst_out_n, 1);
    negs(20);

    // R1 R2 R3 R5: table walk
    for (int i = 0; i < 9; i++) begin
      dly_sel = VECS[i].sel;
      low_cnt = 0;
      btn_a_n = 1'b0; btn_b_n = 1'b0;
      negs(int'(VECS[i].hold));
      btn_a_n = 1'b1; btn_b_n = 1'b1;
      negs(PULSE + 40);
      check(low_cnt == (VECS[i].fires ? PULSE : 0), "R1/R2/R3/R5 vector",
            low_cnt, VECS[i].fires ? PULSE : 0);
    end

    // R4 exact edge, R5 length, R8 lockout
    dly_sel = 2'b00;
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    negs(2001);
    check(rst_out_n == 1'b1, "R4 before edge N+2", rst_out_n, 1);
    negs(1);
    check(rst_out_n == 1'b0, "R4 at edge N+2", rst_out_n, 0);
    negs(PULSE - 1);
    check(rst_out_n == 1'b0, "R5 pulse end-1", rst_out_n, 0);
    negs(1);
    check(rst_out_n == 1'b1, "R5 pulse end", rst_out_n, 1);
    low_cnt = 0;
    negs(3000);
    check(low_cnt == 0, "R8 no retrigger while held", low_cnt, 0);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    negs(3);
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    negs(2500);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    negs(PULSE + 10);
    check(low_cnt == 0, "R8 short idle keeps lockout", low_cnt, 0);
    negs(30);
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    negs(2000);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    negs(PULSE + 40);
    check(low_cnt == PULSE, "R8 re-armed after idle", low_cnt, PULSE);

    // R2 single button
    low_cnt = 0;
    btn_a_n = 1'b0;
    negs(11000);
    btn_a_n = 1'b1;
    negs(20);
    check(low_cnt == 0, "R2 one button only", low_cnt, 0);

    // R9 no tick, no timing
    tick = 1'b0;
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    negs(3000);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    negs(10);
    check(low_cnt == 0, "R9 frozen without tick", low_cnt, 0);
    tick = 1'b1;
    negs(20);

    // R6 supply loss
    supply_ok = 1'b0;
    negs(1);
    check(rst_out_n == 1'b0, "R6 supply low asserts", rst_out_n, 0);
    negs(500);
    check(rst_out_n == 1'b0, "R6 held while supply low", rst_out_n, 0);
    supply_ok = 1'b1;
    negs(PULSE - 1);
    check(rst_out_n == 1'b0, "R6 stretch end-1", rst_out_n, 0);
    negs(1);
    check(rst_out_n == 1'b1, "R6 stretch end", rst_out_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule